// File: doc/BRIEF.md
# Command-Gated Transmit Queue Controller

This block drives the read side of one transmit descriptor queue in buffer memory. A processor programs three pointers: a read pointer, a write pointer and a last-descriptor pointer. It also writes a 16-bit mode register. Two bits of that register matter here. One gates transmission on an explicit command. The other folds transmit data back onto the receive path.

When gating is off and the block is in the running operating mode, descriptors are fetched whenever the queue is non-empty. When gating is on, nothing is fetched until the processor issues a transmit command. No fill threshold applies in either case. After a command, the block fetches one descriptor per cycle from the current read pointer. It stops once the read pointer reaches the last-descriptor pointer and raises an end-of-command flag. While a command is running, a second command is refused. Several frames can be sent under one command.

The mode register accepts writes only in the initialize and memory-active operating modes. Gating can be switched on only in initialize mode, but it can be switched off in either mode.

Top module: `txq_cmd_ctrl`

## Requirements
- R1: After reset, the following are all zero: the mode register, the three pointers, the busy flag, the done flag, the read strobe and the data-valid output.
- R2: With op_mode = 0 (initialize), a mode write stores all 16 bits, visible one cycle later. Bit 14 is the gate enable and bit 15 is the loopback enable.
- R3: With op_mode = 2 (running) or 3 (halted), mode writes are ignored.
- R4: With op_mode = 1 (memory-active), a mode write updates every bit except that bit 14 may be cleared but never set.
- R5: While gating is enabled and no command is running, no memory read occurs, even when the read and write pointers differ. With gating disabled and op_mode = 2, one read per cycle occurs while the read pointer differs from the write pointer.
- R6: A command, taken when gating is enabled and busy is low, raises busy on the next cycle. On each busy cycle the block reads at the read pointer, which then advances by one, modulo 2^PTR_W.
- R7: The run ends with the read at address lptr-1. On the same edge, busy falls and done rises. The number of reads is therefore lptr minus the starting rptr, modulo 2^PTR_W.
- R8: A command given while rptr equals lptr sets done on the next cycle, with no read and no busy.
- R9: A command is ignored while busy is high, and is also ignored while gating is disabled.
- R10: Writing done_clr = 1 clears done on the next cycle. If done is set in that same cycle, the set wins.
- R11: Pointer writes take effect one cycle later when busy is low, and are ignored while busy is high.
- R12: tx_valid is high in the cycle after each read, with tx_data carrying the memory's read data. rx_data equals tx_data when loopback is enabled, and rx_line otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Operating mode: 0 initialize, 1 memory-active, 2 running, 3 halted |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 16 | Mode register write data |
| mode_q | output | 16 | Mode register contents |
| rptr_we | input | 1 | Read pointer write strobe |
| wptr_we | input | 1 | Write pointer write strobe |
| lptr_we | input | 1 | Last-descriptor pointer write strobe |
| ptr_wdata | input | PTR_W | Pointer write data |
| rptr | output | PTR_W | Read pointer |
| wptr | output | PTR_W | Write pointer |
| lptr | output | PTR_W | Last-descriptor pointer |
| tx_cmd | input | 1 | Transmit command strobe |
| done_clr | input | 1 | Write-one-to-clear for done |
| busy | output | 1 | Command run in progress |
| done | output | 1 | End-of-command status |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | PTR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the strobe |
| tx_valid | output | 1 | Transmit data valid |
| tx_data | output | DATA_W | Transmit data |
| rx_line | input | DATA_W | Receive data from the line |
| rx_data | output | DATA_W | Receive data after the loopback select |

## Verification
Mode-register and pointer writes are due one edge after the strobe. A command raises busy one edge after it is sampled. The first read strobe appears combinationally in that same busy cycle, and done rises on the edge that performs the last read. tx_valid trails each read strobe by one edge, while rx_data follows its select combinationally. The bench drives inputs just after a rising edge and samples at the falling edge. Its reference model advances on the same rising edge as the design, so each result is compared in exactly the cycle it is due.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    OPM_INIT   = 2'd0,
    OPM_MEMACT = 2'd1,
    OPM_RUN    = 2'd2,
    OPM_HALT   = 2'd3
  } opm_e;

  localparam int MODE_W   = 16;
  localparam int GATE_BIT = 14;
  localparam int LOOP_BIT = 15;
endpackage

// File: rtl/txq_mode_reg.sv
module txq_mode_reg
  import txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic              gate_en,
  output logic              loop_en
);
  logic [MODE_W-1:0] mode_d;
  logic              mode_ce;

  // Gate bit may be cleared in memory-active mode but only set in initialize mode.
  always_comb begin
    mode_d  = mode_q;
    mode_ce = 1'b0;
    if (we) begin
      unique case (opm_e'(op_mode))
        OPM_INIT: begin
          mode_d  = wdata;
          mode_ce = 1'b1;
        end
        OPM_MEMACT: begin
          mode_d           = wdata;
          mode_d[GATE_BIT] = mode_q[GATE_BIT] & wdata[GATE_BIT];
          mode_ce          = 1'b1;
        end
        default: mode_ce = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_ce) mode_q <= mode_d;
  end

  assign gate_en = mode_q[GATE_BIT];
  assign loop_en = mode_q[LOOP_BIT];
endmodule

// File: rtl/txq_ptr_file.sv
module txq_ptr_file #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             rptr_we,
  input  logic             wptr_we,
  input  logic             lptr_we,
  input  logic [PTR_W-1:0] wdata,
  input  logic             step,
  output logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] lptr
);
  logic [PTR_W-1:0] rptr_d;
  logic             rptr_ce, wptr_ce, lptr_ce;

  always_comb begin
    rptr_d  = rptr;
    rptr_ce = 1'b0;
    if (rptr_we && !busy) begin
      rptr_d  = wdata;
      rptr_ce = 1'b1;
    end else if (step) begin
      rptr_d  = rptr + 1'b1;
      rptr_ce = 1'b1;
    end
  end

  assign wptr_ce = wptr_we & ~busy;
  assign lptr_ce = lptr_we & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rptr <= '0;
    else if (rptr_ce) rptr <= rptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr <= '0;
    else if (wptr_ce) wptr <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lptr <= '0;
    else if (lptr_ce) lptr <= wdata;
  end
endmodule

// File: rtl/txq_tx_seq.sv
module txq_tx_seq #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             run_mode,
  input  logic             tx_cmd,
  input  logic             done_clr,
  input  logic [PTR_W-1:0] rptr,
  input  logic [PTR_W-1:0] wptr,
  input  logic [PTR_W-1:0] lptr,
  output logic             busy,
  output logic             done,
  output logic             rd_en
);
  logic             busy_d, done_d;
  logic             cmd_ok, cmd_empty, free_rd, last_rd;
  logic [PTR_W-1:0] rptr_inc;

  assign rptr_inc  = rptr + 1'b1;
  assign cmd_ok    = gate_en & tx_cmd & ~busy;
  assign cmd_empty = cmd_ok & (rptr == lptr);
  assign free_rd   = ~gate_en & run_mode & (rptr != wptr);
  assign last_rd   = busy & (rptr_inc == lptr);
  assign rd_en     = busy | free_rd;

  always_comb begin
    busy_d = busy;
    if (cmd_ok && !cmd_empty) busy_d = 1'b1;
    else if (last_rd)         busy_d = 1'b0;
    done_d = (done & ~done_clr) | cmd_empty | last_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      busy <= busy_d;
      done <= done_d;
    end
  end
endmodule

// File: rtl/txq_cmd_ctrl.sv
module txq_cmd_ctrl
  import txq_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic              mode_we,
  input  logic [15:0]       mode_wdata,
  output logic [15:0]       mode_q,
  input  logic              rptr_we,
  input  logic              wptr_we,
  input  logic              lptr_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  output logic [PTR_W-1:0]  rptr,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  lptr,
  input  logic              tx_cmd,
  input  logic              done_clr,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] rx_line,
  output logic [DATA_W-1:0] rx_data
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       gate_en, loop_en, run_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign run_mode = (opm_e'(op_mode) == OPM_RUN);

  txq_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .op_mode (op_mode),
    .we      (mode_we),
    .wdata   (mode_wdata),
    .mode_q  (mode_q),
    .gate_en (gate_en),
    .loop_en (loop_en)
  );

  txq_ptr_file #(.PTR_W(PTR_W)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .busy    (busy),
    .rptr_we (rptr_we),
    .wptr_we (wptr_we),
    .lptr_we (lptr_we),
    .wdata   (ptr_wdata),
    .step    (mem_rd_en),
    .rptr    (rptr),
    .wptr    (wptr),
    .lptr    (lptr)
  );

  txq_tx_seq #(.PTR_W(PTR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .gate_en  (gate_en),
    .run_mode (run_mode),
    .tx_cmd   (tx_cmd),
    .done_clr (done_clr),
    .rptr     (rptr),
    .wptr     (wptr),
    .lptr     (lptr),
    .busy     (busy),
    .done     (done),
    .rd_en    (mem_rd_en)
  );

  assign mem_addr = rptr;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tx_valid <= 1'b0;
    else             tx_valid <= mem_rd_en;
  end

  assign tx_data = mem_rdata;
  assign rx_data = loop_en ? tx_data : rx_line;
endmodule

// File: rtl/txq_cmd_ctrl_chk.sv
module txq_cmd_ctrl_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       op_mode,
  input logic             mode_we,
  input logic [15:0]      mode_q,
  input logic             rptr_we,
  input logic [PTR_W-1:0] rptr,
  input logic [PTR_W-1:0] lptr,
  input logic             tx_cmd,
  input logic             done_clr,
  input logic             busy,
  input logic             done,
  input logic             mem_rd_en,
  input logic             tx_valid
);
  a_r3_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && op_mode[1]) |=> $stable(mode_q));

  a_r4_gate_not_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && op_mode == 2'd1 && !mode_q[14]) |=> !mode_q[14]);

  a_r5_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[14] && !busy) |-> !mem_rd_en);

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !(rptr_we && !busy)) |=> rptr == PTR_W'($past(rptr) + 1'b1));

  a_r7_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && PTR_W'(rptr + 1'b1) == lptr) |=> (!busy && done));

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && PTR_W'(rptr + 1'b1) != lptr) |=> busy);

  a_r10_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_clr && !busy && !tx_cmd) |=> !done);

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> tx_valid);
endmodule

bind txq_cmd_ctrl txq_cmd_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .op_mode   (op_mode),
  .mode_we   (mode_we),
  .mode_q    (mode_q),
  .rptr_we   (rptr_we),
  .rptr      (rptr),
  .lptr      (lptr),
  .tx_cmd    (tx_cmd),
  .done_clr  (done_clr),
  .busy      (busy),
  .done      (done),
  .mem_rd_en (mem_rd_en),
  .tx_valid  (tx_valid)
);

// File: tb/test_txq_cmd_ctrl.sv
`timescale 1ns/1ps
module test_txq_cmd_ctrl;
  localparam int PW = 8;
  localparam int DW = 16;
  localparam int PM = 255;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    op_mode;
  logic          mode_we;
  logic [15:0]   mode_wdata;
  logic [15:0]   mode_q;
  logic          rptr_we, wptr_we, lptr_we;
  logic [PW-1:0] ptr_wdata;
  logic [PW-1:0] rptr, wptr, lptr;
  logic          tx_cmd, done_clr;
  logic          busy, done, mem_rd_en, tx_valid;
  logic [PW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, tx_data, rx_line, rx_data;

  int checks = 0;
  int errors = 0;
  bit live = 0;
  int rd_cnt = 0;

  // reference model state
  int  m_mode, m_r, m_w, m_l, m_txaddr;
  bit  m_busy, m_done, m_txv;

  always #2.5 clk = ~clk;

  txq_cmd_ctrl #(.PTR_W(PW), .DATA_W(DW)) i_txq_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .mode_q(mode_q), .rptr_we(rptr_we),
    .wptr_we(wptr_we), .lptr_we(lptr_we), .ptr_wdata(ptr_wdata),
    .rptr(rptr), .wptr(wptr), .lptr(lptr), .tx_cmd(tx_cmd),
    .done_clr(done_clr), .busy(busy), .done(done), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_line(rx_line), .rx_data(rx_data)
  );

  function automatic logic [DW-1:0] mem_word(input int a);
    return DW'(((a * 37) + 16'h1C00) & 16'hFFFF);
  endfunction

  always @(posedge clk) begin
    mem_rdata <= mem_word(int'(mem_addr));
  end

  function automatic bit exp_rd();
    return m_busy || (!m_mode[14] && op_mode == 2'd2 && m_r != m_w);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_r = 0; m_w = 0; m_l = 0; m_txaddr = 0;
      m_busy = 0; m_done = 0; m_txv = 0;
    end else begin
      bit rd, ob, ok, last;
      rd   = exp_rd();
      ob   = m_busy;
      ok   = m_mode[14] && tx_cmd && !ob;
      last = ob && (((m_r + 1) & PM) == m_l);
      m_txv = rd;
      m_txaddr = m_r;
      if (done_clr) m_done = 0;
      if (last || (ok && m_r == m_l)) m_done = 1;
      if (ok && m_r != m_l) m_busy = 1;
      else if (last)        m_busy = 0;
      if (rptr_we && !ob) m_r = int'(ptr_wdata);
      else if (rd)        m_r = (m_r + 1) & PM;
      if (wptr_we && !ob) m_w = int'(ptr_wdata);
      if (lptr_we && !ob) m_l = int'(ptr_wdata);
      if (mode_we) begin
        if (op_mode == 2'd0) m_mode = int'(mode_wdata);
        else if (op_mode == 2'd1)
          m_mode = (int'(mode_wdata) & 16'hBFFF) | (m_mode & int'(mode_wdata) & 16'h4000);
      end
    end
  end

  task automatic cmp(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      cmp(int'(mode_q), m_mode, "R2 mode register");
      cmp(int'(rptr), m_r, "R6 read pointer");
      cmp(int'(wptr), m_w, "R11 write pointer");
      cmp(int'(lptr), m_l, "R11 last pointer");
      cmp(int'(busy), int'(m_busy), "R7 busy");
      cmp(int'(done), int'(m_done), "R10 done");
      cmp(int'(mem_rd_en), int'(exp_rd()), "R5 read strobe");
      if (mem_rd_en) cmp(int'(mem_addr), m_r, "R6 read address");
      cmp(int'(tx_valid), int'(m_txv), "R12 tx_valid");
      if (m_txv) cmp(int'(tx_data), int'(mem_word(m_txaddr)), "R12 tx_data");
      cmp(int'(rx_data), m_mode[15] ? int'(mem_rdata) : int'(rx_line), "R12 rx_data");
      if (mem_rd_en) rd_cnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wmode(input logic [1:0] op, input logic [15:0] v);
    op_mode = op; mode_we = 1'b1; mode_wdata = v;
    tick(1);
    mode_we = 1'b0;
  endtask

  task automatic wptrs(input int r, input int w, input int l);
    ptr_wdata = PW'(r); rptr_we = 1'b1; tick(1); rptr_we = 1'b0;
    ptr_wdata = PW'(w); wptr_we = 1'b1; tick(1); wptr_we = 1'b0;
    ptr_wdata = PW'(l); lptr_we = 1'b1; tick(1); lptr_we = 1'b0;
  endtask

  task automatic cmd();
    tx_cmd = 1'b1; tick(1); tx_cmd = 1'b0;
  endtask

  task automatic dcheck(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_mode = 2'd2; mode_we = 0; mode_wdata = '0;
    rptr_we = 0; wptr_we = 0; lptr_we = 0; ptr_wdata = '0;
    tx_cmd = 0; done_clr = 0; rx_line = 16'h5A5A;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    @(negedge clk);
    // R1 reset values
    dcheck(mode_q == 0 && rptr == 0 && wptr == 0 && lptr == 0 && !busy && !done
           && !mem_rd_en && !tx_valid, "R1 reset state", int'(mode_q), 0);
    live = 1;
    tick(1);

    // R3 writes ignored in running and halted modes
    wmode(2'd2, 16'hFFFF);
    wmode(2'd3, 16'hFFFF);
    @(negedge clk);
    dcheck(mode_q == 16'h0000, "R3 mode locked", int'(mode_q), 0);
    tick(1);

    // R2 full write in initialize mode
    wmode(2'd0, 16'hC123);
    @(negedge clk);
    dcheck(mode_q == 16'hC123, "R2 init write", int'(mode_q), 16'hC123);
    tick(1);

    // R4 memory-active: clear allowed, set refused
    wmode(2'd1, 16'h0000);
    wmode(2'd1, 16'h4007);
    @(negedge clk);
    dcheck(mode_q == 16'h0007, "R4 gate set refused", int'(mode_q), 16'h0007);
    tick(1);

    // gate on, loopback off
    wmode(2'd0, 16'h4000);
    wptrs(2, 6, 5);
    op_mode = 2'd2;
    rd_cnt = 0;
    tick(6);
    @(negedge clk);
    // R5 gated idle queue stays quiet
    dcheck(rd_cnt == 0 && rptr == 2, "R5 gated no reads", rd_cnt, 0);
    tick(1);

    // R6 R7 command run; R9 second command while busy
    rd_cnt = 0;
    cmd();
    @(negedge clk);
    dcheck(busy == 1'b1, "R6 busy after command", int'(busy), 1);
    tick(0);
    cmd();
    tick(6);
    @(negedge clk);
    dcheck(rd_cnt == 3 && rptr == 5 && done && !busy, "R7 three reads then done", rd_cnt, 3);
    tick(1);

    // R10 clear
    done_clr = 1'b1; tick(1); done_clr = 1'b0;
    @(negedge clk);
    dcheck(!done, "R10 done cleared", int'(done), 0);
    tick(1);

    // R8 empty command
    rd_cnt = 0;
    cmd();
    @(negedge clk);
    dcheck(done && !busy && rd_cnt == 0, "R8 immediate done", int'(done), 1);
    tick(1);
    done_clr = 1'b1; tick(1); done_clr = 1'b0;

    // R6 R11 wrap run with pointer write while busy and clear held (R10 set wins)
    wptrs(8'hFE, 3, 2);
    rd_cnt = 0;
    cmd();
    ptr_wdata = 8'h40; lptr_we = 1'b1; done_clr = 1'b1;
    tick(2);
    lptr_we = 1'b0;
    tick(2);
    @(negedge clk);
    dcheck(done && !busy && rd_cnt == 4 && rptr == 2 && lptr == 2,
           "R11 wrap run, pointer write ignored, R10 set wins", rd_cnt, 4);
    tick(1);
    done_clr = 1'b1; tick(1); done_clr = 1'b0;

    // R9 gating off: command ignored; R5 free reads
    wmode(2'd0, 16'h0000);
    op_mode = 2'd2;
    rd_cnt = 0;
    cmd();
    tick(3);
    @(negedge clk);
    dcheck(!busy && !done && rd_cnt == 1 && rptr == 3, "R9 ungated cmd ignored", rd_cnt, 1);
    tick(1);

    // R12 loopback
    wmode(2'd0, 16'h8000);
    op_mode = 2'd2;
    wptrs(3, 7, 0);
    rx_line = 16'h1234;
    tick(6);
    @(negedge clk);
    dcheck(rx_data == tx_data, "R12 loopback", int'(rx_data), int'(tx_data));
    tick(1);
    wmode(2'd0, 16'h0000);
    @(negedge clk);
    dcheck(rx_data == 16'h1234, "R12 line path", int'(rx_data), 16'h1234);
    tick(2);

    live = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule